// File: doc/BRIEF.md
# SMBus Master Transaction Sequencer

This block runs one master transaction on a two-wire serial bus at a time. Software loads a transmit queue with tagged bytes and then writes a command word. The first byte in the queue is the address byte, and a flag on a later byte marks the final byte to send. The command word selects one of four protocols: quick, block write, block read, or a write followed by a read after a repeated start. For reads it also gives a byte count. The sequencer takes bytes from the queue, drives a byte-level bus PHY through a request/done handshake and places received bytes in a receive queue, each with a tag. When the transaction ends it reports a completion code.

Both queues are 64 entries deep. The receive queue has a programmable fill threshold. Four sticky events feed a single interrupt line: receive queue full, threshold reached, transaction finished and transmit queue starved. Each event can be enabled and is cleared by writing 1 to it. Bit timing, clock stretching and pad control belong to the PHY.

Top module: `smb_master_seq`

Register word addresses: 0 command, 1 queue control, 2 event enable, 3 event status, 4 transmit push, 5 receive pop. Command word fields: bit 31 go/busy, bits 27:25 completion code, bits 12:9 protocol, bits 7:0 read count. Event bits in the enable and status words: 31 receive full, 30 threshold, 28 finished, 27 transmit starved. PHY operation codes: 0 start (a repeated start when the bus is already held), 1 write byte, 2 read byte, 3 stop.

## Requirements
- R1: Writing the command word with bit 31 set while idle starts a transaction, and bit 31 reads 1 while it runs. Bit 31 clears by itself at the end, and the finished event (status bit 28) is set at that point. Each PHY request stays asserted with a stable operation code until done.
- R2: Protocol 0x0 (quick) issues start, writes the single address entry and then issues stop. The completion code is 0.
- R3: Protocol 0x7 (block write) issues start and writes queued bytes in order up to and including the entry with bit 31 set. It then issues stop with completion code 0.
- R4: Protocol 0x8 (block read) writes the address entry and then reads the number of bytes given in bits 7:0. It acknowledges every byte except the last, which it NACKs, and then issues stop. In each receive word, bits 7:0 hold the data, bits 31:30 hold 1 for a non-final byte and 2 for the final byte, and bit 29 reads 0.
- R5: Protocol 0xA (process call) writes the address and data entries. When the head entry carries the last flag, it issues a repeated start, writes that entry as the read address and then runs the read phase as in R4.
- R6: A NACK on an address byte ends with completion code 2 and a stop, with no data byte sent.
- R7: A NACK on a data byte ends with completion code 3 and a stop directly after the failing byte.
- R8: Lost arbitration gives completion code 1 with no stop issued. A PHY timeout gives completion code 4 followed by a stop.
- R9: If the transmit queue is empty before the last-flagged entry has gone out, the starved event (bit 27) is set and the sequencer waits. Bytes pushed later resume the transfer. After STALL_LIMIT idle cycles the transaction ends with completion code 5 and a stop.
- R10: A received byte that finds the receive queue full is dropped, and the transaction ends with completion code 6 and a stop. The full event (bit 31) is set when the fill reaches the depth.
- R11: In the queue-control word, bit 31 flushes the receive queue and bit 30 flushes the transmit queue. Bits 13:8 hold the threshold, and bits 22:16 read back the receive fill. The threshold event (bit 30) is set when the fill reaches a non-zero threshold.
- R12: Event status bits are cleared by writing 1 to them. The interrupt output is high exactly when some status bit and its enable bit are both 1.
- R13: A command write while bit 31 is set has no effect on the running transaction or on the protocol and count read back.
- R14: Popping an empty receive queue returns a word with bits 31:30 equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (pops the receive queue at address 5) |
| regAddr | input | 3 | Register word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| irq | output | 1 | Interrupt: OR of enabled event status bits |
| phyReq | output | 1 | PHY operation request, held until phyDone |
| phyOp | output | 2 | PHY operation code |
| phyTxByte | output | 8 | Byte to send for a write operation |
| phyNackOut | output | 1 | NACK the byte being read |
| phyDone | input | 1 | PHY operation complete (one-cycle pulse) |
| phyRxByte | input | 8 | Byte received, valid with phyDone |
| phyNack | input | 1 | Target did not acknowledge the written byte |
| phyArbLost | input | 1 | Arbitration lost during the operation |
| phyTimeout | input | 1 | Bus timeout during the operation |

## Verification
A wrong sequencer state shows up at the PHY port on the very next request. The operation code or byte is out of order, a stop is missing or extra, or the wrong read gets the NACK. The scoreboard catches this at the moment the PHY model accepts the request. Errors in completion-code or busy tracking show up when the command word is read back right after a transaction. Errors in queue and event bookkeeping show up in the fill readback, the tags of popped words and the interrupt level, each read a few cycles after the triggering stimulus.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;

  // register word addresses
  localparam logic [2:0] A_CMD  = 3'd0;
  localparam logic [2:0] A_QCTL = 3'd1;
  localparam logic [2:0] A_IEN  = 3'd2;
  localparam logic [2:0] A_ISTS = 3'd3;
  localparam logic [2:0] A_TXD  = 3'd4;
  localparam logic [2:0] A_RXD  = 3'd5;

  // PHY operation codes
  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_READ  = 2'd2;
  localparam logic [1:0] OP_STOP  = 2'd3;

  // protocol codes
  localparam logic [3:0] PR_QUICK = 4'h0;
  localparam logic [3:0] PR_BWR   = 4'h7;
  localparam logic [3:0] PR_BRD   = 4'h8;
  localparam logic [3:0] PR_PCALL = 4'hA;

  // completion codes
  localparam logic [2:0] ST_OK      = 3'd0;
  localparam logic [2:0] ST_ARB     = 3'd1;
  localparam logic [2:0] ST_NADDR   = 3'd2;
  localparam logic [2:0] ST_NDATA   = 3'd3;
  localparam logic [2:0] ST_TMO     = 3'd4;
  localparam logic [2:0] ST_STARVE  = 3'd5;
  localparam logic [2:0] ST_RXFULL  = 3'd6;

  // receive tags
  localparam logic [1:0] TAG_MID  = 2'd1;
  localparam logic [1:0] TAG_LAST = 2'd2;

  // event index inside the 4-bit event vector
  localparam int EV_STARVE = 0;  // reg bit 27
  localparam int EV_DONE   = 1;  // reg bit 28
  localparam int EV_THR    = 2;  // reg bit 30
  localparam int EV_FULL   = 3;  // reg bit 31

  typedef struct packed {
    logic       txPop;
    logic       rxPush;
    logic [7:0] rxByte;
    logic [1:0] rxTag;
    logic       starve;
    logic       finish;
    logic [2:0] finStatus;
  } ctlStrobe_t;

endpackage

// File: rtl/smb_seq_fifo.sv
module smb_seq_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 9,
  localparam int PTRW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [CNTW-1:0]  count,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTRW-1:0]  wrPtr, rdPtr;
  logic             doPush, doPop;

  assign empty    = (count == '0);
  assign full     = (count == CNTW'(DEPTH));
  assign doPush   = push && !full;
  assign doPop    = pop && !empty;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTRW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTRW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/smb_seq_dp.sv
module smb_seq_dp
  import smb_seq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            regWr,
  input  logic            regRd,
  input  logic [2:0]      regAddr,
  input  logic [31:0]     regWdata,
  output logic [31:0]     regRdata,
  output logic            irq,
  input  ctlStrobe_t      strobe,
  output logic            go,
  output logic [3:0]      proto,
  output logic [7:0]      rdCnt,
  output logic            txEmpty,
  output logic [7:0]      txHeadByte,
  output logic            txHeadLast,
  output logic            rxFull,
  output logic            busy,
  output logic [3:0]      intSts,
  output logic [3:0]      intEn,
  output logic [CNTW-1:0] rxCount
);
  logic [2:0]      statusQ;
  logic [5:0]      thrQ;
  logic [8:0]      txHead;
  logic [9:0]      rxHead;
  logic            rxEmpty, txFull;
  logic [CNTW-1:0] txCount;
  logic            wrCmd, wrQctl, wrIen, wrIsts, wrTx, rdRx;
  logic            rxPushOk, rxPopOk, thrHit, fullHit;
  logic [3:0]      evSet, stsWrBits;

  assign wrCmd  = regWr && regAddr == A_CMD;
  assign wrQctl = regWr && regAddr == A_QCTL;
  assign wrIen  = regWr && regAddr == A_IEN;
  assign wrIsts = regWr && regAddr == A_ISTS;
  assign wrTx   = regWr && regAddr == A_TXD;
  assign rdRx   = regRd && regAddr == A_RXD;

  smb_seq_fifo #(.DEPTH(DEPTH), .WIDTH(9)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .flush(wrQctl && regWdata[30]),
    .push(wrTx), .pushData({regWdata[31], regWdata[7:0]}),
    .pop(strobe.txPop), .headData(txHead),
    .count(txCount), .empty(txEmpty), .full(txFull)
  );

  smb_seq_fifo #(.DEPTH(DEPTH), .WIDTH(10)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .flush(wrQctl && regWdata[31]),
    .push(strobe.rxPush), .pushData({strobe.rxTag, strobe.rxByte}),
    .pop(rdRx), .headData(rxHead),
    .count(rxCount), .empty(rxEmpty), .full(rxFull)
  );

  assign txHeadByte = txHead[7:0];
  assign txHeadLast = txHead[8];

  assign rxPushOk = strobe.rxPush && !rxFull;
  assign rxPopOk  = rdRx && !rxEmpty;
  assign thrHit   = rxPushOk && !rxPopOk && (thrQ != '0) &&
                    (({1'b0, rxCount} + 1'b1) == (CNTW + 1)'(thrQ));
  assign fullHit  = rxPushOk && !rxPopOk && (rxCount == CNTW'(DEPTH - 1));

  always_comb begin
    evSet = '0;
    evSet[EV_STARVE] = strobe.starve;
    evSet[EV_DONE]   = strobe.finish;
    evSet[EV_THR]    = thrHit;
    evSet[EV_FULL]   = fullHit;
    stsWrBits = {regWdata[31], regWdata[30], regWdata[28], regWdata[27]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      go      <= 1'b0;
      statusQ <= ST_OK;
      proto   <= '0;
      rdCnt   <= '0;
      thrQ    <= '0;
      intEn   <= '0;
      intSts  <= '0;
    end else begin
      go <= 1'b0;
      if (wrCmd && !busy && regWdata[31]) begin
        busy    <= 1'b1;
        go      <= 1'b1;
        statusQ <= ST_OK;
        proto   <= regWdata[12:9];
        rdCnt   <= regWdata[7:0];
      end else if (strobe.finish) begin
        busy    <= 1'b0;
        statusQ <= strobe.finStatus;
      end
      if (wrQctl) thrQ <= regWdata[13:8];
      if (wrIen)  intEn <= stsWrBits;
      intSts <= (intSts & ~(wrIsts ? stsWrBits : 4'b0)) | evSet;
    end
  end

  assign irq = |(intSts & intEn);

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_CMD: begin
        regRdata[31]    = busy;
        regRdata[27:25] = statusQ;
        regRdata[12:9]  = proto;
        regRdata[7:0]   = rdCnt;
      end
      A_QCTL: begin
        regRdata[22:16] = 7'(rxCount);
        regRdata[13:8]  = thrQ;
      end
      A_IEN:  {regRdata[31], regRdata[30], regRdata[28], regRdata[27]} = intEn;
      A_ISTS: {regRdata[31], regRdata[30], regRdata[28], regRdata[27]} = intSts;
      A_RXD: begin
        if (!rxEmpty) begin
          regRdata[31:30] = rxHead[9:8];
          regRdata[7:0]   = rxHead[7:0];
        end
      end
      default: regRdata = '0;
    endcase
  end
endmodule

// File: rtl/smb_seq_ctrl.sv
module smb_seq_ctrl
  import smb_seq_pkg::*;
#(
  parameter int STALL_LIMIT = 1000,
  localparam int STW = $clog2(STALL_LIMIT + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [3:0] proto,
  input  logic [7:0] rdCnt,
  input  logic       txEmpty,
  input  logic [7:0] txHeadByte,
  input  logic       txHeadLast,
  input  logic       rxFull,
  output logic       phyReq,
  output logic [1:0] phyOp,
  output logic [7:0] phyTxByte,
  output logic       phyNackOut,
  input  logic       phyDone,
  input  logic [7:0] phyRxByte,
  input  logic       phyNack,
  input  logic       phyArbLost,
  input  logic       phyTimeout,
  output ctlStrobe_t strobe
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_FETCH, S_SEND, S_RECV, S_STOP, S_END} state_e;

  state_e     state;
  logic [2:0] curStatus;
  logic [7:0] curByte, rdLeft;
  logic       curLast, curIsAddr, addrNext;
  logic [STW-1:0] stallCnt;
  logic       readProto, restart, takeHead, busErr;

  assign readProto = (proto == PR_BRD) || (proto == PR_PCALL);
  assign restart   = (proto == PR_PCALL) && txHeadLast && !addrNext;
  assign takeHead  = (state == S_FETCH) && !txEmpty && !restart;
  assign busErr    = phyArbLost || phyTimeout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      curStatus <= ST_OK;
      curByte   <= '0;
      curLast   <= 1'b0;
      curIsAddr <= 1'b0;
      addrNext  <= 1'b0;
      rdLeft    <= '0;
      stallCnt  <= '0;
    end else begin
      case (state)
        S_IDLE: if (go) begin
          addrNext  <= 1'b1;
          curStatus <= ST_OK;
          stallCnt  <= '0;
          state     <= S_START;
        end
        S_START: if (phyDone) begin
          if (phyArbLost) begin
            curStatus <= ST_ARB;
            state     <= S_END;
          end else if (phyTimeout) begin
            curStatus <= ST_TMO;
            state     <= S_STOP;
          end else begin
            state <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (!txEmpty) begin
            stallCnt <= '0;
            if (restart) begin
              addrNext <= 1'b1;
              state    <= S_START;
            end else begin
              curByte   <= txHeadByte;
              curLast   <= txHeadLast;
              curIsAddr <= addrNext;
              addrNext  <= 1'b0;
              state     <= S_SEND;
            end
          end else if (stallCnt == STW'(STALL_LIMIT)) begin
            curStatus <= ST_STARVE;
            state     <= S_STOP;
          end else begin
            stallCnt <= stallCnt + 1'b1;
          end
        end
        S_SEND: if (phyDone) begin
          if (phyArbLost) begin
            curStatus <= ST_ARB;
            state     <= S_END;
          end else if (phyTimeout) begin
            curStatus <= ST_TMO;
            state     <= S_STOP;
          end else if (phyNack) begin
            curStatus <= curIsAddr ? ST_NADDR : ST_NDATA;
            state     <= S_STOP;
          end else if (curLast) begin
            if (readProto && rdCnt != '0) begin
              rdLeft <= rdCnt;
              state  <= S_RECV;
            end else begin
              state <= S_STOP;
            end
          end else begin
            state <= S_FETCH;
          end
        end
        S_RECV: if (phyDone) begin
          if (phyArbLost) begin
            curStatus <= ST_ARB;
            state     <= S_END;
          end else if (phyTimeout) begin
            curStatus <= ST_TMO;
            state     <= S_STOP;
          end else if (rxFull) begin
            curStatus <= ST_RXFULL;
            state     <= S_STOP;
          end else if (rdLeft == 8'd1) begin
            state <= S_STOP;
          end else begin
            rdLeft <= rdLeft - 1'b1;
          end
        end
        S_STOP: if (phyDone) state <= S_END;
        S_END:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    phyReq     = 1'b0;
    phyOp      = OP_START;
    phyTxByte  = curByte;
    phyNackOut = 1'b0;
    case (state)
      S_START: phyReq = 1'b1;
      S_SEND:  begin phyReq = 1'b1; phyOp = OP_WRITE; end
      S_RECV:  begin phyReq = 1'b1; phyOp = OP_READ; phyNackOut = (rdLeft == 8'd1); end
      S_STOP:  begin phyReq = 1'b1; phyOp = OP_STOP; end
      default: ;
    endcase
  end

  always_comb begin
    strobe           = '0;
    strobe.txPop     = takeHead;
    strobe.rxPush    = (state == S_RECV) && phyDone && !busErr && !rxFull;
    strobe.rxByte    = phyRxByte;
    strobe.rxTag     = (rdLeft == 8'd1) ? TAG_LAST : TAG_MID;
    strobe.starve    = (state == S_FETCH) && txEmpty && (stallCnt == '0);
    strobe.finish    = (state == S_END);
    strobe.finStatus = curStatus;
  end
endmodule

// File: rtl/smb_master_seq.sv
module smb_master_seq
  import smb_seq_pkg::*;
#(
  parameter int FIFO_DEPTH  = 64,
  parameter int STALL_LIMIT = 1000,
  localparam int CNTW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        irq,
  output logic        phyReq,
  output logic [1:0]  phyOp,
  output logic [7:0]  phyTxByte,
  output logic        phyNackOut,
  input  logic        phyDone,
  input  logic [7:0]  phyRxByte,
  input  logic        phyNack,
  input  logic        phyArbLost,
  input  logic        phyTimeout
);
  ctlStrobe_t      strobe;
  logic            go, txEmpty, txHeadLast, rxFull, busyQ;
  logic [3:0]      protoQ, intStsQ, intEnQ;
  logic [7:0]      rdCntQ, txHeadByte;
  logic [CNTW-1:0] rxCount;

  smb_seq_dp #(.DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq), .strobe(strobe),
    .go(go), .proto(protoQ), .rdCnt(rdCntQ),
    .txEmpty(txEmpty), .txHeadByte(txHeadByte), .txHeadLast(txHeadLast),
    .rxFull(rxFull), .busy(busyQ), .intSts(intStsQ), .intEn(intEnQ),
    .rxCount(rxCount)
  );

  smb_seq_ctrl #(.STALL_LIMIT(STALL_LIMIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .go(go), .proto(protoQ), .rdCnt(rdCntQ),
    .txEmpty(txEmpty), .txHeadByte(txHeadByte), .txHeadLast(txHeadLast),
    .rxFull(rxFull),
    .phyReq(phyReq), .phyOp(phyOp), .phyTxByte(phyTxByte), .phyNackOut(phyNackOut),
    .phyDone(phyDone), .phyRxByte(phyRxByte), .phyNack(phyNack),
    .phyArbLost(phyArbLost), .phyTimeout(phyTimeout),
    .strobe(strobe)
  );
endmodule

// File: rtl/smb_seq_chk.sv
module smb_seq_chk
  import smb_seq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            regWr,
  input logic [2:0]      regAddr,
  input logic            phyReq,
  input logic [1:0]      phyOp,
  input logic            phyDone,
  input logic            phyArbLost,
  input logic            busyQ,
  input logic [3:0]      protoQ,
  input logic [3:0]      intStsQ,
  input logic [CNTW-1:0] rxCount
);
  p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phyReq && !phyDone |=> phyReq && $stable(phyOp));

  p_req_in_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phyReq |-> busyQ);

  p_done_event_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busyQ) |-> intStsQ[EV_DONE]);

  p_arb_no_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    phyDone && phyArbLost |=> !phyReq);

  p_rx_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rxCount <= CNTW'(DEPTH));

  p_w1c_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(intStsQ[EV_DONE]) |-> $past(regWr && regAddr == A_ISTS));

  p_cmd_locked_r13: assert property (@(posedge clk) disable iff (!rst_n)
    regWr && regAddr == A_CMD && busyQ |=> $stable(protoQ));
endmodule

bind smb_master_seq smb_seq_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .regWr(regWr), .regAddr(regAddr),
  .phyReq(phyReq), .phyOp(phyOp), .phyDone(phyDone), .phyArbLost(phyArbLost),
  .busyQ(busyQ), .protoQ(protoQ), .intStsQ(intStsQ), .rxCount(rxCount)
);

// File: tb/sim_smb_master_seq.sv
module sim_smb_master_seq;
  import smb_seq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irq, phyReq, phyNackOut;
  logic [1:0]  phyOp;
  logic [7:0]  phyTxByte;
  logic        phyDone = 1'b0, phyNack = 1'b0, phyArbLost = 1'b0, phyTimeout = 1'b0;
  logic [7:0]  phyRxByte = '0;

  always #5 clk = ~clk;

  smb_master_seq u0 (
    .clk(clk), .rst_n(rst_n), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq),
    .phyReq(phyReq), .phyOp(phyOp), .phyTxByte(phyTxByte), .phyNackOut(phyNackOut),
    .phyDone(phyDone), .phyRxByte(phyRxByte), .phyNack(phyNack),
    .phyArbLost(phyArbLost), .phyTimeout(phyTimeout)
  );

  int total = 0, bad = 0, monTotal = 0, monBad = 0;
  logic wdFail = 1'b0;
  logic [9:0] expQ[$];

  // PHY model state
  logic phyRst = 1'b0;
  logic pend = 1'b0;
  int   dly = 0, opIdx = 0, rdIdx = 0;
  int   nackAt = -1, arbAt = -1, toAt = -1;
  logic [7:0] rdBase = 8'h30;

  always @(negedge clk) begin
    if (phyRst) begin
      opIdx = 0; rdIdx = 0;
      pend <= 1'b0; phyDone <= 1'b0;
    end else if (phyDone) begin
      phyDone <= 1'b0; phyNack <= 1'b0; phyArbLost <= 1'b0; phyTimeout <= 1'b0;
    end else if (pend) begin
      if (dly == 0) begin phyDone <= 1'b1; pend <= 1'b0; end
      else dly <= dly - 1;
    end else if (phyReq) begin
      pend       <= 1'b1;
      dly        <= 1;
      phyNack    <= (phyOp == OP_WRITE) && (opIdx == nackAt);
      phyArbLost <= (opIdx == arbAt);
      phyTimeout <= (opIdx == toAt);
      phyRxByte  <= rdBase + 8'(rdIdx);
      if (phyOp == OP_READ) rdIdx = rdIdx + 1;
      opIdx = opIdx + 1;
    end
  end

  // monitor: compare each accepted PHY request with the scoreboard queue
  always @(negedge clk) begin
    if (!phyRst && !phyDone && !pend && phyReq) begin
      logic [9:0] act, exp;
      act = {phyOp, (phyOp == OP_WRITE) ? phyTxByte :
                    (phyOp == OP_READ) ? {7'b0, phyNackOut} : 8'h00};
      monTotal++;
      if (expQ.size() == 0) begin
        monBad++;
        $display("FAIL R1-seq unexpected PHY op act=%h exp=<none>", act);
      end else begin
        exp = expQ.pop_front();
        if (act !== exp) begin
          monBad++;
          $display("FAIL R2..R10 PHY op act=%h exp=%h", act, exp);
        end
      end
    end
  end

  function automatic logic [9:0] eop(logic [1:0] op, logic [7:0] b);
    return {op, b};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic pop(output logic [31:0] d);
    @(negedge clk);
    regAddr = A_RXD; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic phySetup(int n, int a, int t, logic [7:0] base);
    nackAt = n; arbAt = a; toAt = t; rdBase = base;
    @(negedge clk); #1 phyRst = 1'b1;
    @(negedge clk); #1 phyRst = 1'b0;
  endtask

  function automatic logic [31:0] cmdw(logic [3:0] p, logic [7:0] n);
    return 32'h8000_0000 | (32'(p) << 9) | 32'(n);
  endfunction

  task automatic waitIdle(output logic [31:0] c);
    for (int i = 0; i < 5000; i++) begin
      rd(A_CMD, c);
      if (!c[31]) break;
    end
  endtask

  task automatic endCheck(string req, logic [2:0] code);
    logic [31:0] c;
    waitIdle(c);
    chk({req, " busy clear"}, {31'b0, c[31]}, 32'd0);
    chk({req, " completion code"}, 32'(c[27:25]), 32'(code));
    chk({req, " all ops seen"}, expQ.size(), 0);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total + monTotal, bad + monBad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    wdFail = 1'b1;
    bad++;
    $display("FAIL watchdog run did not finish act=hung exp=done");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(A_CMD, d);  chk("R1 reset cmd word", d, 32'h0);
    rd(A_ISTS, d); chk("R12 reset status", d, 32'h0);
    rd(A_QCTL, d); chk("R11 reset qctl", d, 32'h0);
    chk("R1 reset phyReq/irq", {30'b0, phyReq, irq}, 32'h0);

    // R2 quick
    phySetup(-1, -1, -1, 8'h30);
    wr(A_TXD, 32'h8000_00A0);
    expQ.push_back(eop(OP_START, 0)); expQ.push_back(eop(OP_WRITE, 8'hA0));
    expQ.push_back(eop(OP_STOP, 0));
    wr(A_CMD, cmdw(PR_QUICK, 0));
    rd(A_CMD, d); chk("R1 busy while running", {31'b0, d[31]}, 32'd1);
    endCheck("R2 quick", ST_OK);
    rd(A_ISTS, d); chk("R1 finished event", d & 32'h1000_0000, 32'h1000_0000);
    chk("R12 irq masked", {31'b0, irq}, 32'd0);
    wr(A_IEN, 32'h1000_0000);
    @(negedge clk); chk("R12 irq enabled", {31'b0, irq}, 32'd1);
    wr(A_ISTS, 32'h1000_0000);
    @(negedge clk); chk("R12 w1c clears irq", {31'b0, irq}, 32'd0);
    rd(A_ISTS, d); chk("R12 w1c status", d, 32'h0);
    wr(A_IEN, 32'h0);

    // R3 block write
    phySetup(-1, -1, -1, 8'h30);
    wr(A_TXD, 32'hA4); wr(A_TXD, 32'h11); wr(A_TXD, 32'h22); wr(A_TXD, 32'h8000_0033);
    expQ.push_back(eop(OP_START, 0)); expQ.push_back(eop(OP_WRITE, 8'hA4));
    expQ.push_back(eop(OP_WRITE, 8'h11)); expQ.push_back(eop(OP_WRITE, 8'h22));
    expQ.push_back(eop(OP_WRITE, 8'h33)); expQ.push_back(eop(OP_STOP, 0));
    wr(A_CMD, cmdw(PR_BWR, 0));
    endCheck("R3 block write", ST_OK);

    // R4 block read with threshold R11
    phySetup(-1, -1, -1, 8'h30);
    wr(A_ISTS, 32'hFFFF_FFFF);
    wr(A_QCTL, 32'h0000_0400);
    wr(A_TXD, 32'h8000_00A5);
    expQ.push_back(eop(OP_START, 0)); expQ.push_back(eop(OP_WRITE, 8'hA5));
    expQ.push_back(eop(OP_READ, 0)); expQ.push_back(eop(OP_READ, 0));
    expQ.push_back(eop(OP_READ, 0)); expQ.push_back(eop(OP_READ, 1));
    expQ.push_back(eop(OP_STOP, 0));
    wr(A_CMD, cmdw(PR_BRD, 4));
    endCheck("R4 block read", ST_OK);
    rd(A_QCTL, d); chk("R11 fill and threshold readback", d, 32'h0004_0400);
    rd(A_ISTS, d); chk("R11 threshold event", d & 32'h4000_0000, 32'h4000_0000);
    for (int i = 0; i < 4; i++) begin
      pop(d);
      chk("R4 rx word", d, {(i == 3) ? 2'd2 : 2'd1, 22'b0, 8'h30 + 8'(i)});
    end
    pop(d); chk("R14 empty pop tag", 32'(d[31:30]), 32'd0);

    // R5 process call
    phySetup(-1, -1, -1, 8'h50);
    wr(A_QCTL, 32'h0);
    wr(A_TXD, 32'hA4); wr(A_TXD, 32'h07); wr(A_TXD, 32'h8000_00A5);
    expQ.push_back(eop(OP_START, 0)); expQ.push_back(eop(OP_WRITE, 8'hA4));
    expQ.push_back(eop(OP_WRITE, 8'h07)); expQ.push_back(eop(OP_START, 0));
    expQ.push_back(eop(OP_WRITE, 8'hA5)); expQ.push_back(eop(OP_READ, 0));
    expQ.push_back(eop(OP_READ, 1)); expQ.push_back(eop(OP_STOP, 0));
    wr(A_CMD, cmdw(PR_PCALL, 2));
    endCheck("R5 process call", ST_OK);
    pop(d); chk("R5 rx first", d, 32'h4000_0050);
    pop(d); chk("R5 rx last", d, 32'h8000_0051);

    // R6 address NACK
    phySetup(1, -1, -1, 8'h30);
    wr(A_TXD, 32'hA4); wr(A_TXD, 32'h01); wr(A_TXD, 32'h8000_0002);
    expQ.push_back(eop(OP_START, 0)); expQ.push_back(eop(OP_WRITE, 8'hA4));
    expQ.push_back(eop(OP_STOP, 0));
    wr(A_CMD, cmdw(PR_BWR, 0));
    endCheck("R6 address nack", ST_NADDR);
    wr(A_QCTL, 32'h4000_0000);

    // R7 data NACK
    phySetup(2, -1, -1, 8'h30);
    wr(A_TXD, 32'hA4); wr(A_TXD, 32'h01); wr(A_TXD, 32'h02); wr(A_TXD, 32'h8000_0003);
    expQ.push_back(eop(OP_START, 0)); expQ.push_back(eop(OP_WRITE, 8'hA4));
    expQ.push_back(eop(OP_WRITE, 8'h01)); expQ.push_back(eop(OP_STOP, 0));
    wr(A_CMD, cmdw(PR_BWR, 0));
    endCheck("R7 data nack", ST_NDATA);
    wr(A_QCTL, 32'h4000_0000);

    // R8 arbitration lost at start
    phySetup(-1, 0, -1, 8'h30);
    wr(A_TXD, 32'h8000_00A0);
    expQ.push_back(eop(OP_START, 0));
    wr(A_CMD, cmdw(PR_QUICK, 0));
    endCheck("R8 arb lost", ST_ARB);
    wr(A_QCTL, 32'h4000_0000);

    // R8 timeout on address write
    phySetup(-1, -1, 1, 8'h30);
    wr(A_TXD, 32'h8000_00A0);
    expQ.push_back(eop(OP_START, 0)); expQ.push_back(eop(OP_WRITE, 8'hA0));
    expQ.push_back(eop(OP_STOP, 0));
    wr(A_CMD, cmdw(PR_QUICK, 0));
    endCheck("R8 timeout", ST_TMO);

    // R9 starvation with late refill
    phySetup(-1, -1, -1, 8'h30);
    wr(A_ISTS, 32'hFFFF_FFFF);
    wr(A_TXD, 32'hA4); wr(A_TXD, 32'h01);
    expQ.push_back(eop(OP_START, 0)); expQ.push_back(eop(OP_WRITE, 8'hA4));
    expQ.push_back(eop(OP_WRITE, 8'h01)); expQ.push_back(eop(OP_WRITE, 8'h02));
    expQ.push_back(eop(OP_STOP, 0));
    wr(A_CMD, cmdw(PR_BWR, 0));
    repeat (40) @(negedge clk);
    rd(A_ISTS, d); chk("R9 starved event", d & 32'h0800_0000, 32'h0800_0000);
    rd(A_CMD, d);  chk("R9 waits busy", {31'b0, d[31]}, 32'd1);
    wr(A_TXD, 32'h8000_0002);
    endCheck("R9 refill resumes", ST_OK);

    // R9 starvation limit
    phySetup(-1, -1, -1, 8'h30);
    wr(A_TXD, 32'hA4);
    expQ.push_back(eop(OP_START, 0)); expQ.push_back(eop(OP_WRITE, 8'hA4));
    expQ.push_back(eop(OP_STOP, 0));
    wr(A_CMD, cmdw(PR_BWR, 0));
    endCheck("R9 starve limit", ST_STARVE);

    // R10 receive queue overflow
    phySetup(-1, -1, -1, 8'h00);
    wr(A_ISTS, 32'hFFFF_FFFF);
    wr(A_QCTL, 32'h8000_0000);
    wr(A_TXD, 32'h8000_00A5);
    expQ.push_back(eop(OP_START, 0)); expQ.push_back(eop(OP_WRITE, 8'hA5));
    for (int i = 0; i < 65; i++) expQ.push_back(eop(OP_READ, 0));
    expQ.push_back(eop(OP_STOP, 0));
    wr(A_CMD, cmdw(PR_BRD, 70));
    endCheck("R10 rx full", ST_RXFULL);
    rd(A_QCTL, d); chk("R10 fill at depth", 32'(d[22:16]), 32'd64);
    rd(A_ISTS, d); chk("R10 full event", d & 32'h8000_0000, 32'h8000_0000);
    pop(d); chk("R10 oldest kept", d, 32'h4000_0000);
    wr(A_QCTL, 32'h8000_0000);
    rd(A_QCTL, d); chk("R11 rx flush", 32'(d[22:16]), 32'd0);

    // R13 command write while busy
    phySetup(-1, -1, -1, 8'h70);
    wr(A_TXD, 32'h8000_00A5);
    expQ.push_back(eop(OP_START, 0)); expQ.push_back(eop(OP_WRITE, 8'hA5));
    expQ.push_back(eop(OP_READ, 0)); expQ.push_back(eop(OP_READ, 0));
    expQ.push_back(eop(OP_READ, 1)); expQ.push_back(eop(OP_STOP, 0));
    wr(A_CMD, cmdw(PR_BRD, 3));
    wr(A_CMD, cmdw(PR_QUICK, 9));
    rd(A_CMD, d); chk("R13 fields unchanged", {d[31], 18'b0, d[12:0]},
                      {1'b1, 18'b0, 4'h8, 1'b0, 8'd3});
    endCheck("R13 ignored write", ST_OK);
    rd(A_QCTL, d); chk("R13 read count kept", 32'(d[22:16]), 32'd3);

    if (!wdFail) finishRun();
  end
endmodule